// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address stream for a four-beat burst into a synchronous burst memory. When a new-address strobe is seen, it captures a full-width address. On later clocks it steps only the two lowest address bits through a four-beat group. The bits above them stay fixed at the captured value.

A static ordering pin selects one of two orders. The linear order counts the low bits upward modulo four. The interleaved order XORs the starting low bits with the beat number. An active-low advance input moves the burst one beat per clock. While it is held high, the burst waits and the address does not change.

There are two independent active-low strobes. Either one loads a new address, and a load always beats an advance in the same cycle. Control pins are plain level signals. No data stream passes through the block, so it has no valid/ready handshake. Reset is synchronous and active high.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its state, and after that edge `addr_out` and `low_out` are all zeros.
- R2: If `load_p_n` is low, `load_c_n` is low, or both are low at a rising edge, then after that edge `addr_out` equals the `addr_in` sampled at that edge.
- R3: A load interrupts any burst in progress and resets the beat count to zero. It takes priority over `adv_n` low in the same cycle.
- R4: With `mode_ilv` = 0 (linear), the low two bits on beat k are (start + k) mod 4.
- R5: With `mode_ilv` = 1 (interleaved), the low two bits on beat k are start XOR k.
- R6: With no load and `adv_n` high at an edge, `addr_out` keeps its value (wait state).
- R7: During a burst, `addr_out[AW-1:2]` keeps the loaded value, with no carry out of the low bits. After the fourth beat, a further advance wraps back to the first address of the group.
- R8: With both strobes high, `addr_in` has no effect on `addr_out`.
- R9: `low_out` always equals `addr_out[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_p_n | input | 1 | First new-address strobe, active low |
| load_c_n | input | 1 | Second new-address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_ilv | input | 1 | Order select: 0 linear, 1 interleaved (held static) |
| addr_in | input | AW | External address to capture |
| addr_out | output | AW | Current burst address |
| low_out | output | 2 | Current sequenced low two bits |

## Verification
The bench targets five corner cases, and each has a distinct failure signature:
- **Linear wrap from 11 to 00.** A design that lets the carry ripple into the upper bits would show the upper field incremented.
- **Load in the same cycle as advance.** A design that gave advance priority, or kept the old beat count, would show the new address already one beat ahead.
- **Reload in mid-burst.** The same stale-beat bug shows up here.
- **Wait states with a changing `addr_in`.** A design that captured the address without a strobe, or ignored `adv_n`, would show a moved address.
- **Fifth advance in both orders.** A design that stopped after four beats, or that used increment in interleaved mode, would miss the wrap back to the first address of the group.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    SEQ_LINEAR     = 1'b0,
    SEQ_INTERLEAVE = 1'b1
  } seq_mode_e;

  // Low-bit address for a given beat of a group starting at 'start'.
  function automatic beat_t seq_low(input beat_t start, input beat_t beat, input seq_mode_e mode);
    beat_t r;
    if (mode == SEQ_INTERLEAVE) r = start ^ beat;
    else                        r = start + beat;   // wraps modulo 4 by width
    return r;
  endfunction
endpackage

// File: rtl/bsq_addr_reg.sv
module bsq_addr_reg #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (load) base_q <= addr_in;
  end

  // R8: captured address only changes on a load
  p_base_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(base_q));
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  adv_n,
  output beat_t beat_q
);
  always_ff @(posedge clk) begin
    if (rst)         beat_q <= '0;
    else if (load)   beat_q <= '0;
    else if (!adv_n) beat_q <= beat_q + beat_t'(1);
  end

  p_load_clears_beat_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_q == '0));

  p_adv_steps_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n) |=> (beat_q == beat_t'($past(beat_q) + 2'd1)));

  p_wait_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(beat_q));
endmodule

// File: rtl/bsq_low_map.sv
module bsq_low_map
  import burst_seq_pkg::*;
(
  input  beat_t     start,
  input  beat_t     beat,
  input  seq_mode_e mode,
  output beat_t     low
);
  always_comb low = seq_low(start, beat, mode);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_p_n,
  input  logic          load_c_n,
  input  logic          adv_n,
  input  logic          mode_ilv,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    low_out
);
  localparam int UPW = AW - BEAT_W;

  logic          load;
  logic [AW-1:0] base_q;
  beat_t         beat_q;
  beat_t         low;
  seq_mode_e     mode;

  assign load = !load_p_n || !load_c_n;
  assign mode = seq_mode_e'(mode_ilv);

  bsq_addr_reg #(.AW(AW)) u_areg (
    .clk(clk), .rst(rst), .load(load), .addr_in(addr_in), .base_q(base_q)
  );

  bsq_beat_ctr u_beat (
    .clk(clk), .rst(rst), .load(load), .adv_n(adv_n), .beat_q(beat_q)
  );

  bsq_low_map u_map (
    .start(base_q[BEAT_W-1:0]), .beat(beat_q), .mode(mode), .low(low)
  );

  assign addr_out = {base_q[AW-1:BEAT_W], low};
  assign low_out  = low;

  // R2: a load presents the captured address on the next cycle
  p_load_visible_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr_out == $past(addr_in)));

  // R7: upper field never moves without a load
  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> (addr_out[AW-1:BEAT_W] == $past(addr_out[AW-1:BEAT_W])));

  // R6: a wait state leaves the address unchanged (mode held static)
  p_wait_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n && $stable(mode_ilv)) |=> $stable(addr_out));

  initial assert (UPW >= 1) else $error("AW must exceed 2");
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 18;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_p_n, load_c_n, adv_n, mode_ilv;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic [1:0]    low_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  burst_addr_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .load_p_n(load_p_n), .load_c_n(load_c_n),
    .adv_n(adv_n), .mode_ilv(mode_ilv), .addr_in(addr_in),
    .addr_out(addr_out), .low_out(low_out)
  );

  // {load_p_n, load_c_n, adv_n, mode_ilv, addr_in, expected addr_out}
  localparam logic [43:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,1'b0,18'h15A6E,18'h15A6E, 4'd2}, // R2 load, linear start 10
    {1'b1,1'b1,1'b0,1'b0,18'h00000,18'h15A6F, 4'd4}, // R4 beat 1
    {1'b1,1'b1,1'b0,1'b0,18'h00000,18'h15A6C, 4'd7}, // R4/R7 11->00, no carry
    {1'b1,1'b1,1'b1,1'b0,18'h3FFFF,18'h15A6C, 4'd6}, // R6 wait, R8 addr_in ignored
    {1'b1,1'b1,1'b0,1'b0,18'h00000,18'h15A6D, 4'd4}, // R4 beat 3
    {1'b1,1'b1,1'b0,1'b0,18'h00000,18'h15A6E, 4'd7}, // R7 wrap to first
    {1'b1,1'b0,1'b0,1'b0,18'h0FFFF,18'h0FFFF, 4'd3}, // R3 load beats advance
    {1'b1,1'b1,1'b0,1'b0,18'h00000,18'h0FFFC, 4'd7}, // R7 no carry into upper
    {1'b0,1'b1,1'b1,1'b0,18'h00001,18'h00001, 4'd3}, // R3 reload mid-burst
    {1'b1,1'b0,1'b1,1'b1,18'h2A4D5,18'h2A4D5, 4'd2}, // R2 load, interleaved start 01
    {1'b1,1'b1,1'b0,1'b1,18'h00000,18'h2A4D4, 4'd5}, // R5 01^1
    {1'b1,1'b1,1'b0,1'b1,18'h00000,18'h2A4D7, 4'd5}, // R5 01^2
    {1'b1,1'b1,1'b0,1'b1,18'h00000,18'h2A4D6, 4'd5}, // R5 01^3
    {1'b1,1'b1,1'b0,1'b1,18'h00000,18'h2A4D5, 4'd7}, // R7 interleaved wrap
    {1'b1,1'b1,1'b1,1'b1,18'h11111,18'h2A4D5, 4'd6}, // R6 wait
    {1'b0,1'b0,1'b1,1'b1,18'h1234A,18'h1234A, 4'd2}, // R2 both strobes
    {1'b1,1'b1,1'b0,1'b1,18'h00000,18'h1234B, 4'd5}, // R5 10^1
    {1'b1,1'b1,1'b0,1'b1,18'h00000,18'h12348, 4'd5}, // R5 10^2
    {1'b1,1'b1,1'b0,1'b1,18'h00000,18'h12349, 4'd5}, // R5 10^3
    {1'b1,1'b1,1'b1,1'b1,18'h00000,18'h12349, 4'd8}  // R8 no strobe
  };

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    rst = 1'b1; load_p_n = 1'b1; load_c_n = 1'b1; adv_n = 1'b1; mode_ilv = 1'b0; addr_in = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 addr_out", addr_out, '0);
    check("R1 low_out", AW'(low_out), '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {load_p_n, load_c_n, adv_n, mode_ilv, addr_in} = VEC[i][43:22];
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), addr_out, VEC[i][21:4]);
      check($sformatf("R9 vec%0d", i), AW'(low_out), AW'(VEC[i][5:4]));
    end

    // R1: reset during a live burst clears everything
    load_p_n = 1'b1; load_c_n = 1'b1; adv_n = 1'b0; rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid-burst addr_out", addr_out, '0);
    check("R1 mid-burst low_out", AW'(low_out), '0);
    rst = 1'b0; adv_n = 1'b1;

    // R4: linear from 00 after load with advance held low (load wins, R3)
    mode_ilv = 1'b0; load_c_n = 1'b0; adv_n = 1'b0; addr_in = 18'h3FFF0;
    @(posedge clk);
    #1;
    check("R3 load priority", addr_out, 18'h3FFF0);
    load_c_n = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk);
      #1;
      check("R4 linear from 00", addr_out, 18'h3FFF0 | AW'(k % 4));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule